// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block is a synthesizable stand-in for a small pipelined synchronous SRAM. Its control style needs no idle cycle between reads and writes. A command is sampled on a rising clock edge while the clock enable is active. The command either loads a fresh address or advances an internal burst counter that steps through a 4-word group. The group is walked in interleaved or linear order, chosen by a static strap. Write data follows its command on a fixed pipeline slot. Four byte lanes of 9 bits each (8 data bits plus a parity bit) can be masked one by one.

The bidirectional data bus is split into an input vector, an output vector and one output-enable flag, so a pad ring or a bench can model it. The bus keeps the fixed slot timing of an SRAM pin interface and has no valid/ready handshake. The clock enable is the only way to stall, and it freezes the whole pipeline, output data included.

The array holds 2^ADDR_W words of LANES*LANE_W bits (64 x 36 by default). A read placed right behind a write to the same word returns the new data through a bypass, lane by lane.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `cen_n` is high, a clock edge changes no state: `dq_out` and `dq_oe` hold, no command is taken, and `dq_in` is not written.
- R2: A load command selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on that edge. Any other combination deselects it. The chip enables are not looked at on advance edges.
- R3: `adv_ld_n`=0 on an enabled edge loads `addr` as a new access. `adv_ld_n`=1 advances the burst of the last selected load. An advance taken while the device is deselected is ignored: it produces no read data and no write.
- R4: The burst acts on address bits [1:0] only, and the upper bits stay fixed. For beat k (k=0..3) from start s, `mode`=1 gives s XOR k and `mode`=0 gives (s+k) mod 4. For example, a start of 5 gives 5,4,7,6 in interleaved order and 5,6,7,4 in linear order.
- R5: On a write, lane i (bits [9i+8:9i]) is written only if `bw_n[i]`=0. Lanes with `bw_n[i]`=1 keep their old contents.
- R6: For a read command taken on enabled edge n, the word appears on `dq_out` after enabled edge n+1. It stays there until the next enabled edge.
- R7: For a write command taken on enabled edge n, `dq_in` is sampled on enabled edge n+2.
- R8: `dq_oe` is high only while read data is held and `oe_n`=0. It is low during the slot in which a write's data is driven, on the first cycle after leaving deselect, and whenever the device is deselected, whatever the value of `oe_n`.
- R9: A read of a word whose write data is being sampled on the same edge returns the new data in the lanes that the write enables.
- R10: Every advance beat repeats the read/write type and the `bw_n` lane mask of the load that started the burst, ignoring `we_n` and `bw_n` on the advance edge.
- R11: After `rst_n` is released, the device is deselected, `dq_oe` is low, and advances are ignored until a selected load arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high stalls everything |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | Active-low write command on a load |
| addr | input | ADDR_W | Word address for a load |
| bw_n | input | LANES | Active-low byte-lane write selects |
| mode | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oe_n | input | 1 | Active-low output enable |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The hardest case to reach from the ports is the bypass of R9. It needs a write command immediately followed by a read of the same word, with the write data arriving on the very edge where the read fetches the array, and with stalls possibly wedged between them. Directed sequences set up this hazard for full and partial lane masks. The random phase also issues short streams of loads and advances over a small address space with frequent stalls, so such collisions, and bursts that wrap around their 4-word group, happen many times in both burst orders.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

  // Offset of a burst beat inside its group; callers truncate to the burst width.
  function automatic logic [7:0] beat_index(input burst_order_e ord,
                                            input logic [7:0] start,
                                            input logic [7:0] beat);
    if (ord == ORD_INTERLEAVED) return start ^ beat;
    return start + beat;
  endfunction

endpackage

// File: rtl/pbs_cmd_ctl.sv
module pbs_cmd_ctl
  import pbs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sel,
  input  logic              load,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  burst_order_e      order,
  output logic              s1_valid,
  output logic              s1_write,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_bw_n
);

  logic               active_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic               bwr_q;
  logic [LANES-1:0]   bbw_q;

  logic [BURST_W-1:0] beat_nx;
  logic [BURST_W-1:0] low_nx;

  assign beat_nx = beat_q + BURST_W'(1);
  assign low_nx  = BURST_W'(beat_index(order, 8'(base_q[BURST_W-1:0]), 8'(beat_nx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      bwr_q    <= 1'b0;
      bbw_q    <= '1;
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_addr  <= '0;
      s1_bw_n  <= '1;
    end else if (clk_en) begin
      if (load) begin
        if (sel) begin
          active_q <= 1'b1;
          base_q   <= addr;
          beat_q   <= '0;
          bwr_q    <= wr;
          bbw_q    <= bw_n;
          s1_valid <= 1'b1;
          s1_write <= wr;
          s1_addr  <= addr;
          s1_bw_n  <= bw_n;
        end else begin
          active_q <= 1'b0;
          s1_valid <= 1'b0;
        end
      end else if (active_q) begin
        beat_q   <= beat_nx;
        s1_valid <= 1'b1;
        s1_write <= bwr_q;
        s1_addr  <= {base_q[ADDR_W-1:BURST_W], low_nx};
        s1_bw_n  <= bbw_q;
      end else begin
        s1_valid <= 1'b0;
      end
    end
  end

  // R3: advance while deselected produces no access
  p_adv_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load && !active_q) |=> !s1_valid);

  // R2: unselected load yields no access
  p_unselected_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load && !sel) |=> !s1_valid);

  // R4: advancing never leaves the 4-word group
  p_burst_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load && active_q) |=>
      (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

endmodule

// File: rtl/pbs_lane_array.sv
module pbs_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    clk_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_bw_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic hit;
  assign hit = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic              lane_wr;

    assign lane_wr = wr_en && !wr_bw_n[g];

    always_ff @(posedge clk) begin
      if (clk_en && lane_wr) mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    // bypass: new lane data wins over the stored word
    assign rd_data[g*LANE_W +: LANE_W] =
      (hit && !wr_bw_n[g]) ? wr_data[g*LANE_W +: LANE_W] : mem_q[rd_addr];
  end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adv_ld_n,
  input  logic                    we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    mode,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              clk_en;
  logic              sel;
  burst_order_e      order;

  logic              s1_valid;
  logic              s1_write;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_bw_n;

  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_bw_n;

  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] dout_q;
  logic              rd_vld_q;

  assign clk_en = !cen_n;
  assign sel    = !ce1_n && ce2 && !ce3_n;
  assign order  = burst_order_e'(mode);

  pbs_cmd_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sel      (sel),
    .load     (!adv_ld_n),
    .wr       (!we_n),
    .addr     (addr),
    .bw_n     (bw_n),
    .order    (order),
    .s1_valid (s1_valid),
    .s1_write (s1_write),
    .s1_addr  (s1_addr),
    .s1_bw_n  (s1_bw_n)
  );

  // second stage: a write waits here one slot for its data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw_n <= '1;
    end else if (clk_en) begin
      s2_wr   <= s1_valid && s1_write;
      s2_addr <= s1_addr;
      s2_bw_n <= s1_bw_n;
    end
  end

  pbs_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .clk_en  (clk_en),
    .wr_en   (s2_wr),
    .wr_addr (s2_addr),
    .wr_bw_n (s2_bw_n),
    .wr_data (dq_in),
    .rd_addr (s1_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      dout_q   <= '0;
    end else if (clk_en) begin
      rd_vld_q <= s1_valid && !s1_write;
      if (s1_valid && !s1_write) dout_q <= rd_data;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = rd_vld_q && !oe_n;

  // R1: a stalled edge leaves the output stage untouched
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dout_q) && $stable(rd_vld_q)));

  // R6: a read in stage one is on the bus after the next enabled edge
  p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_valid && !s1_write) |=> rd_vld_q);

  // R8: the slot carrying write data is never driven
  p_write_slot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_valid && s1_write) |=> !dq_oe);

  // R8: nothing is driven after an empty stage one
  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !s1_valid) |=> !dq_oe);

  // R9: lane 0 of a colliding read takes the incoming write data
  p_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s2_wr && s1_valid && !s1_write && (s1_addr == s2_addr) && !s2_bw_n[0])
      |=> (dout_q[LANE_W-1:0] == $past(dq_in[LANE_W-1:0])));

endmodule

// File: tb/tb_pipe_burst_sram.sv
`timescale 1ns/1ps
module tb_pipe_burst_sram;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          s_cen = 1'b0, s_ce1 = 1'b1, s_ce2 = 1'b1, s_ce3 = 1'b0;
  logic          s_adv = 1'b0, s_we = 1'b1, s_mode = 1'b1, s_oe = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic [NL-1:0] s_bw = '1;
  logic [DW-1:0] s_din = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  pipe_burst_sram dut (
    .clk(clk), .rst_n(rst_n), .cen_n(s_cen), .ce1_n(s_ce1), .ce2(s_ce2),
    .ce3_n(s_ce3), .adv_ld_n(s_adv), .we_n(s_we), .addr(s_addr), .bw_n(s_bw),
    .mode(s_mode), .oe_n(s_oe), .dq_in(s_din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] ref_mem [1<<AW];
  logic          m_active = 0, m_wr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [NL-1:0] m_bw = '1;
  logic          m1_valid = 0, m1_wr = 0, m2_wr = 0;
  logic [AW-1:0] m1_addr = '0, m2_addr = '0;
  logic [NL-1:0] m1_bw = '1, m2_bw = '1;
  logic          e_valid = 0;
  logic [DW-1:0] e_data = '0;

  function automatic logic [1:0] order_low(input logic interleaved, input logic [1:0] s,
                                           input logic [1:0] k);
    return interleaved ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [DW-1:0] rv;
    if (s_cen) return;
    rv = ref_mem[m1_addr];
    if (m2_wr && m2_addr == m1_addr)
      for (int i = 0; i < NL; i++) if (!m2_bw[i]) rv[i*LW +: LW] = s_din[i*LW +: LW];
    e_valid = m1_valid && !m1_wr;
    if (e_valid) e_data = rv;
    if (m2_wr)
      for (int i = 0; i < NL; i++) if (!m2_bw[i]) ref_mem[m2_addr][i*LW +: LW] = s_din[i*LW +: LW];
    m2_wr = m1_valid && m1_wr; m2_addr = m1_addr; m2_bw = m1_bw;
    if (!s_adv) begin
      if (!s_ce1 && s_ce2 && !s_ce3) begin
        m_active = 1; m_base = s_addr; m_beat = 0; m_wr = !s_we; m_bw = s_bw;
        m1_valid = 1; m1_addr = s_addr; m1_wr = !s_we; m1_bw = s_bw;
      end else begin
        m_active = 0; m1_valid = 0;
      end
    end else if (m_active) begin
      m_beat = m_beat + 2'd1;
      m1_valid = 1;
      m1_addr = {m_base[AW-1:2], order_low(s_mode, m_base[1:0], m_beat)};
      m1_wr = m_wr; m1_bw = m_bw;
    end else begin
      m1_valid = 0;
    end
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    chk("R8 dq_oe", dq_oe === (e_valid && !s_oe), {35'd0, dq_oe}, {35'd0, e_valid && !s_oe});
    if (e_valid && !s_oe) chk("R6 read data", dq_out === e_data, dq_out, e_data);
  endtask

  function automatic logic [DW-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  task automatic load_ce(input logic c1, input logic c2, input logic c3, input logic w,
                         input logic [AW-1:0] a, input logic [NL-1:0] b, input logic [DW-1:0] d);
    s_cen = 0; s_ce1 = c1; s_ce2 = c2; s_ce3 = c3; s_adv = 0;
    s_we = !w; s_addr = a; s_bw = b; s_din = d;
    tick();
  endtask

  task automatic load(input logic w, input logic [AW-1:0] a, input logic [NL-1:0] b,
                      input logic [DW-1:0] d);
    load_ce(1'b0, 1'b1, 1'b0, w, a, b, d);
  endtask

  task automatic adv(input logic [DW-1:0] d);
    s_cen = 0; s_adv = 1; s_we = $urandom() % 2; s_bw = 4'($urandom()); s_din = d;
    tick();
  endtask

  task automatic desel(input logic [DW-1:0] d);
    load_ce(1'b1, 1'b1, 1'b0, 1'b0, '0, '1, d);
  endtask

  task automatic stall();
    s_cen = 1; s_adv = $urandom() % 2; s_we = $urandom() % 2; s_din = rnd();
    tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, o, exp;
    logic [DW-1:0] od [4];
    logic [DW-1:0] dd [4];
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;

    // reset: R11
    repeat (3) @(negedge clk);
    chk("R11 no drive in reset", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    rst_n = 1'b1;
    s_ce1 = 0; s_ce2 = 1; s_ce3 = 0;
    adv(rnd()); adv(rnd());
    chk("R11 advance after reset", dq_oe === 1'b0, {35'd0, dq_oe}, '0);

    // fill every word
    for (int b = 0; b < (1 << AW) / 4; b++) begin
      load(1'b1, AW'(b * 4), '0, rnd());
      adv(rnd()); adv(rnd()); adv(rnd());
    end
    desel(rnd()); desel(rnd()); desel(rnd());

    // R4 interleaved then linear from start 5
    s_mode = 1;
    load(1'b0, 6'd5, '1, rnd());
    adv(rnd()); chk("R4 il beat0", dq_out === ref_mem[5], dq_out, ref_mem[5]);
    adv(rnd()); chk("R4 il beat1", dq_out === ref_mem[4], dq_out, ref_mem[4]);
    adv(rnd()); chk("R4 il beat2", dq_out === ref_mem[7], dq_out, ref_mem[7]);
    desel(rnd()); chk("R4 il beat3", dq_out === ref_mem[6], dq_out, ref_mem[6]);
    desel(rnd()); chk("R8 after deselect", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    s_mode = 0;
    load(1'b0, 6'd5, '1, rnd());
    adv(rnd()); chk("R4 lin beat0", dq_out === ref_mem[5], dq_out, ref_mem[5]);
    adv(rnd()); chk("R4 lin beat1", dq_out === ref_mem[6], dq_out, ref_mem[6]);
    adv(rnd()); chk("R4 lin beat2", dq_out === ref_mem[7], dq_out, ref_mem[7]);
    desel(rnd()); chk("R4 lin beat3", dq_out === ref_mem[4], dq_out, ref_mem[4]);
    desel(rnd());

    // R1 stall during a read burst
    load(1'b0, 6'd8, '1, rnd());
    adv(rnd());
    stall(); chk("R1 hold data", dq_out === ref_mem[8] && dq_oe, dq_out, ref_mem[8]);
    stall(); chk("R1 hold data", dq_out === ref_mem[8] && dq_oe, dq_out, ref_mem[8]);
    adv(rnd()); chk("R1 resume", dq_out === ref_mem[9], dq_out, ref_mem[9]);
    desel(rnd()); desel(rnd());

    // R2 each enable alone deselects; enables ignored on advance
    load_ce(1'b1, 1'b1, 1'b0, 1'b0, 6'd3, '1, rnd()); desel(rnd());
    chk("R2 ce1_n high", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    load_ce(1'b0, 1'b0, 1'b0, 1'b0, 6'd3, '1, rnd()); desel(rnd());
    chk("R2 ce2 low", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    load_ce(1'b0, 1'b1, 1'b1, 1'b0, 6'd3, '1, rnd()); desel(rnd());
    chk("R2 ce3_n high", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    load(1'b0, 6'd12, '1, rnd());
    s_ce1 = 1; adv(rnd());
    s_ce1 = 1; adv(rnd());
    chk("R2 enables ignored on advance", dq_out === ref_mem[13] && dq_oe, dq_out, ref_mem[13]);
    desel(rnd()); desel(rnd());

    // R3 advance while deselected is ignored
    o = ref_mem[31];
    load(1'b1, 6'd30, '0, rnd()); desel(rnd());
    adv(rnd()); chk("R3 idle advance", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    adv(rnd()); adv(rnd()); desel(rnd());
    load(1'b0, 6'd31, '1, rnd()); desel(rnd());
    chk("R3 no stray write", dq_out === o, dq_out, o);
    desel(rnd());

    // R7 data sampled two enabled edges after the command
    d = rnd();
    load(1'b1, 6'd20, '0, rnd()); desel(rnd()); desel(d);
    load(1'b0, 6'd20, '1, rnd()); desel(rnd());
    chk("R7 data slot", dq_out === d, dq_out, d);

    // R5 partial lanes: bw_n=0101 writes lanes 1 and 3
    o = ref_mem[21]; d = rnd();
    load(1'b1, 6'd21, 4'b0101, rnd()); desel(rnd()); desel(d);
    exp = {d[35:27], o[26:18], d[17:9], o[8:0]};
    load(1'b0, 6'd21, '1, rnd()); desel(rnd());
    chk("R5 lane mask", dq_out === exp, dq_out, exp);

    // R10 write burst inherits mask 1100 (lanes 0,1) and write type
    s_mode = 1;
    for (int k = 0; k < 4; k++) begin od[k] = ref_mem[24 + k]; dd[k] = rnd(); end
    load(1'b1, 6'd24, 4'b1100, rnd());
    adv(rnd()); adv(dd[0]); adv(dd[1]); desel(dd[2]); desel(dd[3]);
    load(1'b0, 6'd24, '1, rnd());
    for (int k = 0; k < 4; k++) begin
      if (k < 3) adv(rnd()); else desel(rnd());
      exp = {od[k][35:18], dd[k][17:0]};
      chk("R10 burst inherits", dq_out === exp, dq_out, exp);
    end
    desel(rnd());

    // R9 back-to-back write then read of the same word
    d = rnd();
    load(1'b1, 6'd9, '0, rnd()); load(1'b0, 6'd9, '1, rnd()); desel(d);
    chk("R9 forward full", dq_out === d && dq_oe, dq_out, d);
    o = ref_mem[10]; d = rnd();
    load(1'b1, 6'd10, 4'b1110, rnd()); load(1'b0, 6'd10, '1, rnd()); desel(d);
    exp = {o[35:9], d[8:0]};
    chk("R9 forward lane0", dq_out === exp, dq_out, exp);
    desel(rnd());

    // R8 read, write, read: write data slot not driven; oe_n high blocks
    load(1'b0, 6'd3, '1, rnd()); load(1'b1, 6'd3, '0, rnd());
    chk("R8 read slot driven", dq_oe === 1'b1, {35'd0, dq_oe}, 36'd1);
    load(1'b0, 6'd4, '1, rnd());
    chk("R8 write slot quiet", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    s_oe = 1; desel(rnd());
    chk("R8 oe_n high", dq_oe === 1'b0, {35'd0, dq_oe}, '0);
    s_oe = 0; desel(rnd());

    // random traffic in both orders
    for (int ph = 0; ph < 2; ph++) begin
      s_mode = (ph == 0);
      for (int n = 0; n < 3000; n++) begin
        int r;
        r = $urandom() % 100;
        s_oe = ($urandom() % 8 == 0);
        if (r < 15) stall();
        else if (r < 25) desel(rnd());
        else if (r < 55) load(1'($urandom()), AW'($urandom() % 16), (($urandom() % 3) == 0) ? 4'($urandom()) : 4'h0, rnd());
        else adv(rnd());
      end
      s_oe = 0;
      desel(rnd()); desel(rnd()); desel(rnd());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule